// File: doc/BRIEF.md
# Transmit Statistics Register Guard

This block is the processor-facing register slave for a bank of transmit statistics counters in an Ethernet MAC. Each counter is a full 32-bit word at its own word offset. The transmitter drives one event strobe per counter, and each strobe adds one to that counter. The processor can read or preset any counter through a single-beat request port. Each request produces a registered response one cycle later.

Every request is sorted into an access class before it can have any effect:

- **Refused source:** the request comes from the internal bus master rather than the processor.
- **Burst:** the request is a burst transfer.
- **Reserved:** the request uses a reserved address or a width other than a full word.
- **Normal:** the request targets a counter, the status register or the read-only information register.

Each illegal class leaves the registers untouched and has its own side effect. A burst sets a register-error status bit, and that bit drives the non-maskable interrupt output. A reserved or refused read returns zero data with the data-error flag set. A write to the read-only register is dropped without any error.

The status bits stay set until the processor writes a one to them.

Top module: `txstat_regs`

## Requirements
- R1: Counter k (0 to NUM_CNT-1) sits at word offset k. A full-word write (req_size = 2'b10) loads it, and a full-word read returns it.
- R2: Each cycle in which evt_inc[k] is high adds one to counter k. Strobes for different counters in the same cycle are all counted.
- R3: A counter that holds all ones wraps to zero on its next increment.
- R4: When a processor write and an event strobe hit the same counter in the same cycle, the counter takes the written value and the increment is lost.
- R5: A burst request (req_burst = 1) from the processor changes no counter and sets status bit 0. A burst read returns zero data with rsp_derr low.
- R6: nmi is high exactly while status bit 0 is set, and it falls once that bit is cleared.
- R7: A read of a reserved offset (above NUM_CNT+1) sets status bit 1 and returns zero data with rsp_derr high.
- R8: A write to a reserved offset sets status bit 1 and changes no register.
- R9: A byte-size (2'b00) or half-word-size (2'b01) access to any register is handled as a reserved access: status bit 1 is set, nothing is written, and a read returns rsp_derr high.
- R10: A request with req_src = 1 (internal bus master) is refused. It sets status bit 2, changes no register, and a read returns zero with rsp_derr high.
- R11: The information register at offset NUM_CNT+1 reads back NUM_CNT. Writes to it are dropped and set no status bit.
- R12: The status register at offset NUM_CNT reads {29'b0, src_err, bus_err, reg_err}. Writing a one to a bit clears that bit.
- R13: rsp_valid is high in the cycle after each request and low in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset |
| req_size | input | 2 | 00 byte, 01 half word, 10 word |
| req_burst | input | 1 | Request is part of a burst |
| req_src | input | 1 | 0 = processor, 1 = internal bus master |
| req_wdata | input | 32 | Write data |
| evt_inc | input | NUM_CNT | Per-counter transmit event strobes |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data (zero for writes and rejected reads) |
| rsp_derr | output | 1 | Data-error flag on a read response |
| nmi | output | 1 | Non-maskable interrupt level |

## Verification
Two functions can act on the same counter in the same cycle: a processor write and a transmit event strobe. The bench raises the strobe on the same falling edge on which it presents the write to that counter. In that same cycle it also raises the strobe of a neighbouring counter. It then reads back both counters. It expects the written value in the targeted counter, with the increment lost, and exactly one count in the neighbour.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

  typedef enum logic [2:0] {
    CL_IDLE,
    CL_REFUSED,
    CL_BURST,
    CL_RESERVED,
    CL_CNT,
    CL_STAT,
    CL_INFO
  } acc_class_e;

  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam int ST_W   = 3;
  localparam int ST_REG = 0;
  localparam int ST_BUS = 1;
  localparam int ST_SRC = 2;

  // Order of precedence: source, burst, width, then address.
  function automatic acc_class_e classify(input logic valid, input logic src,
                                          input logic burst, input logic [1:0] size,
                                          input logic is_cnt, input logic is_stat,
                                          input logic is_info);
    if (!valid)                 return CL_IDLE;
    else if (src)               return CL_REFUSED;
    else if (burst)             return CL_BURST;
    else if (size != SZ_WORD)   return CL_RESERVED;
    else if (is_cnt)            return CL_CNT;
    else if (is_stat)           return CL_STAT;
    else if (is_info)           return CL_INFO;
    else                        return CL_RESERVED;
  endfunction

endpackage

// File: rtl/txstat_decode.sv
module txstat_decode
  import txstat_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int NUM_CNT = 15
) (
  input  logic              req_valid,
  input  logic              req_src,
  input  logic              req_burst,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output acc_class_e        acc_class
);
  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(NUM_CNT);
  localparam logic [ADDR_W-1:0] INFO_OFF = ADDR_W'(NUM_CNT + 1);

  logic is_cnt, is_stat, is_info;

  always_comb begin
    is_cnt    = req_addr < STAT_OFF;
    is_stat   = req_addr == STAT_OFF;
    is_info   = req_addr == INFO_OFF;
    acc_class = classify(req_valid, req_src, req_burst, req_size,
                         is_cnt, is_stat, is_info);
  end
endmodule

// File: rtl/txstat_counter.sv
module txstat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  // Write has priority; increment wraps naturally at all ones.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic w, input logic [CNT_W-1:0] wv,
                                                  input logic i);
    if (w)      return wv;
    else if (i) return cur + CNT_W'(1);
    else        return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= next_count(value, wr_en, wr_val, inc);
  end
endmodule

// File: rtl/txstat_status.sv
module txstat_status #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] bits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= (bits & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/txstat_regs.sv
module txstat_regs
  import txstat_pkg::*;
#(
  parameter int NUM_CNT = 15,
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic               req_burst,
  input  logic               req_src,
  input  logic [31:0]        req_wdata,
  input  logic [NUM_CNT-1:0] evt_inc,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_derr,
  output logic               nmi
);
  localparam logic [31:0] INFO_VAL = 32'(NUM_CNT);

  acc_class_e                 acc_class;
  logic [NUM_CNT-1:0]         cnt_sel;
  logic [NUM_CNT-1:0]         cnt_wr_hit;
  logic [NUM_CNT*CNT_W-1:0]   cnt_flat;
  logic [ST_W-1:0]            err_set;
  logic [ST_W-1:0]            stat_clr;
  logic [ST_W-1:0]            stat_bits;
  logic [31:0]                rd_mux;
  logic                       rd_derr;

  txstat_decode #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT)) u_dec (
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_burst (req_burst),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .acc_class (acc_class)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    assign cnt_sel[k]    = (acc_class == CL_CNT) && (req_addr == ADDR_W'(k));
    assign cnt_wr_hit[k] = cnt_sel[k] && req_write;

    txstat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cnt_wr_hit[k]),
      .wr_val (req_wdata[CNT_W-1:0]),
      .inc    (evt_inc[k]),
      .value  (cnt_flat[k*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    err_set          = '0;
    err_set[ST_REG]  = acc_class == CL_BURST;
    err_set[ST_BUS]  = acc_class == CL_RESERVED;
    err_set[ST_SRC]  = acc_class == CL_REFUSED;
    stat_clr         = (acc_class == CL_STAT && req_write) ? req_wdata[ST_W-1:0] : '0;
  end

  txstat_status #(.W(ST_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (err_set),
    .clr_mask (stat_clr),
    .bits     (stat_bits)
  );

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (cnt_sel[k]) rd_mux = rd_mux | 32'(cnt_flat[k*CNT_W +: CNT_W]);
    if (acc_class == CL_STAT) rd_mux = 32'(stat_bits);
    if (acc_class == CL_INFO) rd_mux = INFO_VAL;
    rd_derr = (acc_class == CL_RESERVED) || (acc_class == CL_REFUSED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_derr  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
      rsp_derr  <= req_valid && !req_write && rd_derr;
    end
  end

  assign nmi = stat_bits[ST_REG];
endmodule

// File: rtl/txstat_regs_chk.sv
module txstat_regs_chk #(
  parameter int NUM_CNT = 15,
  parameter int ADDR_W  = 5,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               req_burst,
  input logic               req_src,
  input logic [31:0]        req_wdata,
  input logic [NUM_CNT-1:0] evt_inc,
  input logic               rsp_valid,
  input logic [31:0]        rsp_rdata,
  input logic               rsp_derr,
  input logic               nmi,
  input logic [NUM_CNT-1:0] cnt_wr_hit,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic [2:0]         stat_bits,
  input logic [2:0]         stat_clr
);
  localparam logic [ADDR_W-1:0] LAST_LIVE = ADDR_W'(NUM_CNT + 1);

  // R13
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R13
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R5
  burst_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_src && req_burst |=> nmi);

  // R6
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi && !stat_clr[0] |=> nmi);

  // R10
  refuse_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_src && !req_write |=> rsp_derr && (rsp_rdata == 32'd0) && stat_bits[2]);

  // R7
  rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_src && !req_burst && !req_write && (req_addr > LAST_LIVE)
    |=> rsp_derr && stat_bits[1]);

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt_chk
    // R4
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_hit[k] |=> cnt_flat[k*CNT_W +: CNT_W] == $past(req_wdata[CNT_W-1:0]));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_inc[k] && !cnt_wr_hit[k]
      |=> cnt_flat[k*CNT_W +: CNT_W] == $past(cnt_flat[k*CNT_W +: CNT_W]) + CNT_W'(1));
  end
endmodule

bind txstat_regs txstat_regs_chk #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_burst  (req_burst),
  .req_src    (req_src),
  .req_wdata  (req_wdata),
  .evt_inc    (evt_inc),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_derr   (rsp_derr),
  .nmi        (nmi),
  .cnt_wr_hit (cnt_wr_hit),
  .cnt_flat   (cnt_flat),
  .stat_bits  (stat_bits),
  .stat_clr   (stat_clr)
);

// File: tb/txstat_regs_bench.sv
module txstat_regs_bench;
  localparam int NUM_CNT = 15;
  localparam int ADDR_W  = 5;
  localparam logic [1:0] SZ_W = 2'b10;
  localparam logic [1:0] SZ_H = 2'b01;

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [1:0]  size;
    logic        burst;
    logic        src;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_derr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd3,  SZ_W, 1'b0, 1'b0, 32'h12345678, 32'h0,        1'b0, 4'd1},  // R1
    '{1'b0, 5'd3,  SZ_W, 1'b0, 1'b0, 32'h0,        32'h12345678, 1'b0, 4'd1},  // R1
    '{1'b1, 5'd14, SZ_W, 1'b0, 1'b0, 32'h000000A5, 32'h0,        1'b0, 4'd1},  // R1
    '{1'b0, 5'd14, SZ_W, 1'b0, 1'b0, 32'h0,        32'h000000A5, 1'b0, 4'd1},  // R1
    '{1'b0, 5'd16, SZ_W, 1'b0, 1'b0, 32'h0,        32'd15,       1'b0, 4'd11}, // R11
    '{1'b1, 5'd16, SZ_W, 1'b0, 1'b0, 32'hDEAD,     32'h0,        1'b0, 4'd11}, // R11
    '{1'b0, 5'd16, SZ_W, 1'b0, 1'b0, 32'h0,        32'd15,       1'b0, 4'd11}, // R11
    '{1'b0, 5'd15, SZ_W, 1'b0, 1'b0, 32'h0,        32'd0,        1'b0, 4'd11}, // R11
    '{1'b0, 5'd20, SZ_W, 1'b0, 1'b0, 32'h0,        32'd0,        1'b1, 4'd7},  // R7
    '{1'b0, 5'd15, SZ_W, 1'b0, 1'b0, 32'h0,        32'd2,        1'b0, 4'd7},  // R7
    '{1'b1, 5'd15, SZ_W, 1'b0, 1'b0, 32'd2,        32'h0,        1'b0, 4'd12}, // R12
    '{1'b0, 5'd15, SZ_W, 1'b0, 1'b0, 32'h0,        32'd0,        1'b0, 4'd12}, // R12
    '{1'b1, 5'd25, SZ_W, 1'b0, 1'b0, 32'h55,       32'h0,        1'b0, 4'd8},  // R8
    '{1'b0, 5'd15, SZ_W, 1'b0, 1'b0, 32'h0,        32'd2,        1'b0, 4'd8},  // R8
    '{1'b1, 5'd15, SZ_W, 1'b0, 1'b0, 32'd2,        32'h0,        1'b0, 4'd12}, // R12
    '{1'b0, 5'd3,  SZ_H, 1'b0, 1'b0, 32'h0,        32'd0,        1'b1, 4'd9},  // R9
    '{1'b1, 5'd3,  SZ_H, 1'b0, 1'b0, 32'h0,        32'h0,        1'b0, 4'd9},  // R9
    '{1'b0, 5'd3,  SZ_W, 1'b0, 1'b0, 32'h0,        32'h12345678, 1'b0, 4'd9},  // R9
    '{1'b0, 5'd3,  SZ_W, 1'b0, 1'b1, 32'h0,        32'd0,        1'b1, 4'd10}, // R10
    '{1'b1, 5'd3,  SZ_W, 1'b0, 1'b1, 32'h0,        32'h0,        1'b0, 4'd10}, // R10
    '{1'b0, 5'd3,  SZ_W, 1'b0, 1'b0, 32'h0,        32'h12345678, 1'b0, 4'd10}, // R10
    '{1'b0, 5'd15, SZ_W, 1'b0, 1'b0, 32'h0,        32'd6,        1'b0, 4'd10}, // R10
    '{1'b1, 5'd15, SZ_W, 1'b0, 1'b0, 32'd6,        32'h0,        1'b0, 4'd12}, // R12
    '{1'b0, 5'd15, SZ_W, 1'b0, 1'b0, 32'h0,        32'd0,        1'b0, 4'd12}  // R12
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_valid, req_write, req_burst, req_src;
  logic [ADDR_W-1:0]  req_addr;
  logic [1:0]         req_size;
  logic [31:0]        req_wdata;
  logic [NUM_CNT-1:0] evt_inc;
  logic               rsp_valid, rsp_derr, nmi;
  logic [31:0]        rsp_rdata;

  logic        s_valid, s_derr;
  logic [31:0] s_data;
  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  txstat_regs #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .CNT_W(32)) u_txstat_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_burst(req_burst), .req_src(req_src),
    .req_wdata(req_wdata), .evt_inc(evt_inc), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_derr(rsp_derr), .nmi(nmi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with the response sampled.
  task automatic acc(input logic wr, input logic [4:0] a, input logic [1:0] sz,
                     input logic bu, input logic sr, input logic [31:0] wd);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_burst = bu;   req_src = sr;   req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_burst = 1'b0; req_src = 1'b0;
    req_size = SZ_W; req_wdata = '0;
    s_valid = rsp_valid; s_data = rsp_rdata; s_derr = rsp_derr;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = SZ_W; req_burst = 1'b0; req_src = 1'b0; req_wdata = '0; evt_inc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R13, R6)
    chk("R13 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R6 reset nmi", 32'(nmi), 32'd0);
    acc(1'b0, 5'd0, SZ_W, 1'b0, 1'b0, 32'h0);
    chk("R1 reset counter", s_data, 32'd0);
    chk("R13 response valid", 32'(s_valid), 32'd1);
    @(negedge clk);
    chk("R13 response idle", 32'(rsp_valid), 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].burst, VECS[i].src, VECS[i].wdata);
      chk($sformatf("R%0d vec %0d rdata", VECS[i].req, i), s_data, VECS[i].exp_rd);
      chk($sformatf("R%0d vec %0d derr", VECS[i].req, i), 32'(s_derr), 32'(VECS[i].exp_derr));
    end

    // R2: strobes, three on counter 5 and one on counter 6 concurrently
    evt_inc[5] = 1'b1; evt_inc[6] = 1'b1;
    @(negedge clk); evt_inc[6] = 1'b0;
    repeat (2) @(negedge clk);
    evt_inc[5] = 1'b0;
    acc(1'b0, 5'd5, SZ_W, 1'b0, 1'b0, 32'h0);
    chk("R2 counter5", s_data, 32'd3);
    acc(1'b0, 5'd6, SZ_W, 1'b0, 1'b0, 32'h0);
    chk("R2 counter6", s_data, 32'd1);

    // R3: wrap from all ones
    acc(1'b1, 5'd7, SZ_W, 1'b0, 1'b0, 32'hFFFF_FFFF);
    evt_inc[7] = 1'b1; @(negedge clk); evt_inc[7] = 1'b0;
    acc(1'b0, 5'd7, SZ_W, 1'b0, 1'b0, 32'h0);
    chk("R3 wrap", s_data, 32'd0);

    // R4: write and strobe on counter 8 together, neighbour 9 strobed too
    evt_inc[8] = 1'b1; evt_inc[9] = 1'b1;
    acc(1'b1, 5'd8, SZ_W, 1'b0, 1'b0, 32'd100);
    evt_inc = '0;
    acc(1'b0, 5'd8, SZ_W, 1'b0, 1'b0, 32'h0);
    chk("R4 write wins", s_data, 32'd100);
    acc(1'b0, 5'd9, SZ_W, 1'b0, 1'b0, 32'h0);
    chk("R4 neighbour counted", s_data, 32'd1);

    // R5: burst write ignored, raises nmi
    acc(1'b1, 5'd8, SZ_W, 1'b1, 1'b0, 32'd0);
    chk("R5 burst nmi", 32'(nmi), 32'd1);
    acc(1'b0, 5'd8, SZ_W, 1'b0, 1'b0, 32'h0);
    chk("R5 burst write dropped", s_data, 32'd100);
    acc(1'b0, 5'd8, SZ_W, 1'b1, 1'b0, 32'h0);
    chk("R5 burst read data", s_data, 32'd0);
    chk("R5 burst read derr", 32'(s_derr), 32'd0);
    acc(1'b0, 5'd15, SZ_W, 1'b0, 1'b0, 32'h0);
    chk("R5 status bit0", s_data, 32'd1);
    // R6: level held until cleared
    chk("R6 nmi held", 32'(nmi), 32'd1);
    acc(1'b1, 5'd15, SZ_W, 1'b0, 1'b0, 32'd1);
    chk("R6 nmi cleared", 32'(nmi), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule